// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Controller

This block sits between a set of interrupt request lines and a processor core. Each source has a flag bit, an enable bit and a 3-bit priority. Requests are captured into the flags on a per-instruction-cycle strobe. During the following cycle the block finds the best pending source and compares it with the processor's current priority level. If the source wins, the block issues a one-cycle take strobe together with the vector address of the winner and the priority level the core must adopt.

The core's priority level is held here. It can be raised by a take and rewritten by software, which is how a service routine returns or lowers its level. A trap-active input sets a fourth, topmost level bit, and that blocks every maskable source. Vectors come from a primary table or an alternate table of the same layout, chosen by a select input. When a take happens while the core is sleeping or idle, a wake-up output is raised in the same cycle.

A small state machine sequences each instruction cycle. Its states are ST_WAIT (no sample to judge), ST_EVAL (flags freshly sampled, arbitration in progress) and ST_TAKE (strobe presented). Its transitions are:
- WAIT→EVAL on `cycle_start`, WAIT→WAIT otherwise.
- EVAL→TAKE when a source beats the level.
- EVAL→EVAL on `cycle_start` with no winner, EVAL→WAIT otherwise.
- TAKE→EVAL on `cycle_start`, TAKE→WAIT otherwise.

Top module: `irq_arbiter`

## Requirements
- R1: On a clock edge where `cycle_start` is 1, every `req_i` bit that is 1 sets its flag. When a set and a `flag_clr_i` clear hit the same flag in the same cycle, the set wins. Flags are visible on `flags_o` one cycle later.
- R2: A source takes part in arbitration only when its flag is 1, its enable bit is 1 and its priority is nonzero. Priority 0 disables the source.
- R3: In the cycle after a `cycle_start` edge (ST_EVAL), the block takes an interrupt only if the best pending priority is strictly greater than `level_o`. `take_o` is then high for exactly the next cycle.
- R4: A take loads the winner's priority into the level register and drives the same value on `new_ipl_o` while `take_o` is high.
- R5: `vec_addr_o` equals the table base plus twice the winning index. The base is ALT_BASE when `alt_sel_i` is 1 during ST_EVAL, and PRI_BASE otherwise.
- R6: Among pending sources with equal top priority, the lowest index wins.
- R7: `ipl_we_i` writes `ipl_wdata_i` into the level register. A take load in the same cycle overrides the software write.
- R8: `level_o` is {`trap_i`, level register}. Bit 3 is 1 only while `trap_i` is 1, and while it is 1 no take occurs.
- R9: `wake_o` is 1 exactly when `take_o` is 1 and `sleep_i` is 1.
- R10: `flag_clr_i` bits clear their flags, so that a source lowered and cleared by software does not fire again.
- R11: `en_we_i` loads the whole enable vector, and `prio_we_i` loads the priority of source `prio_sel_i`. Both take effect for the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_start | input | 1 | Instruction-cycle start strobe; samples requests |
| req_i | input | NSRC | Raw request lines |
| flag_clr_i | input | NSRC | Per-source flag clear |
| flags_o | output | NSRC | Flag register contents |
| en_we_i | input | 1 | Enable vector write strobe |
| en_wdata_i | input | NSRC | Enable vector write data |
| prio_we_i | input | 1 | Priority write strobe |
| prio_sel_i | input | IDX_W | Source selected for priority write |
| prio_wdata_i | input | PRIO_W | Priority write data |
| ipl_we_i | input | 1 | Level register write strobe |
| ipl_wdata_i | input | PRIO_W | Level register write data |
| alt_sel_i | input | 1 | 1 selects the alternate vector table |
| trap_i | input | 1 | Trap in progress |
| sleep_i | input | 1 | Core is in sleep or idle |
| take_o | output | 1 | Interrupt take strobe |
| vec_addr_o | output | ADDR_W | Vector address of the winner |
| new_ipl_o | output | PRIO_W | Priority level to adopt |
| level_o | output | PRIO_W+1 | Current level, trap bit on top |
| wake_o | output | 1 | Wake-up request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a request sample and a software flag clear on one source. The second is a take load and a software level write. The bench provokes each pair on purpose, by pulsing `flag_clr_i` with a matching request during `cycle_start` and by writing the level in the ST_EVAL cycle of a winning source. It then judges `flags_o` and `level_o` against a behavioural model that applies set-over-clear and take-over-write. The same model follows a long stream of pseudo-random requests, writes, trap and sleep activity and compares every output on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_EVAL = 2'd1,
        ST_TAKE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cycle_start,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flags_o
);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_bit
            logic set_b;
            assign set_b = cycle_start & req_i[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flags_o[g] <= 1'b0;
                else if (set_b)
                    flags_o[g] <= 1'b1;
                else if (clr_i[g])
                    flags_o[g] <= 1'b0;
            end

            a_r1_sample_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (cycle_start && req_i[g]) |=> flags_o[g]);

            a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !(cycle_start && req_i[g])) |=> !flags_o[g]);
        end
    endgenerate

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_we_i,
    input  logic [NSRC-1:0]               en_wdata_i,
    input  logic                          prio_we_i,
    input  logic [IDX_W-1:0]              prio_sel_i,
    input  logic [PRIO_W-1:0]             prio_wdata_i,
    input  logic                          ipl_we_i,
    input  logic [PRIO_W-1:0]             ipl_wdata_i,
    input  logic                          take_load_i,
    input  logic [PRIO_W-1:0]             take_prio_i,
    output logic [NSRC-1:0]               en_o,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [PRIO_W-1:0]             ipl_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (en_we_i)
            en_o <= en_wdata_i;
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_prio
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prio_o[g] <= '0;
                else if (prio_we_i && (prio_sel_i == IDX_W'(g)))
                    prio_o[g] <= prio_wdata_i;
            end
        end
    endgenerate

    // A hardware take has precedence over a software level write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ipl_o <= '0;
        else if (take_load_i)
            ipl_o <= take_prio_i;
        else if (ipl_we_i)
            ipl_o <= ipl_wdata_i;
    end

    a_r7_take_over_write: assert property (@(posedge clk) disable iff (!rst_n)
        take_load_i |=> (ipl_o == $past(take_prio_i)));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]             flags_i,
    input  logic [NSRC-1:0]             en_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        valid_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           prio_o
);

    logic [NSRC-1:0] pend;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_pend
            assign pend[g] = flags_i[g] & en_i[g] & (|prio_i[g]);
        end
    endgenerate

    // Scan downward with >= so that a lower index replaces an equal one.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (prio_i[i] >= prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int PRIO_W   = 3,
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PRI_BASE = 16'h0004,
    parameter logic [ADDR_W-1:0] ALT_BASE = 16'h0084,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cycle_start,
    input  logic [NSRC-1:0]     req_i,
    input  logic [NSRC-1:0]     flag_clr_i,
    output logic [NSRC-1:0]     flags_o,
    input  logic                en_we_i,
    input  logic [NSRC-1:0]     en_wdata_i,
    input  logic                prio_we_i,
    input  logic [IDX_W-1:0]    prio_sel_i,
    input  logic [PRIO_W-1:0]   prio_wdata_i,
    input  logic                ipl_we_i,
    input  logic [PRIO_W-1:0]   ipl_wdata_i,
    input  logic                alt_sel_i,
    input  logic                trap_i,
    input  logic                sleep_i,
    output logic                take_o,
    output logic [ADDR_W-1:0]   vec_addr_o,
    output logic [PRIO_W-1:0]   new_ipl_o,
    output logic [PRIO_W:0]     level_o,
    output logic                wake_o
);

    arb_state_e state_q, state_d;

    logic [NSRC-1:0]             en_q;
    logic [NSRC-1:0][PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]           ipl_q;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio;
    logic                        win_go;
    logic [ADDR_W-1:0]           base_sel;

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .req_i       (req_i),
        .clr_i       (flag_clr_i),
        .flags_o     (flags_o)
    );

    irq_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_we_i      (en_we_i),
        .en_wdata_i   (en_wdata_i),
        .prio_we_i    (prio_we_i),
        .prio_sel_i   (prio_sel_i),
        .prio_wdata_i (prio_wdata_i),
        .ipl_we_i     (ipl_we_i),
        .ipl_wdata_i  (ipl_wdata_i),
        .take_load_i  (win_go),
        .take_prio_i  (win_prio),
        .en_o         (en_q),
        .prio_o       (prio_q),
        .ipl_o        (ipl_q)
    );

    irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
        .flags_i (flags_o),
        .en_i    (en_q),
        .prio_i  (prio_q),
        .valid_o (win_valid),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    assign level_o  = {trap_i, ipl_q};
    assign win_go   = (state_q == ST_EVAL) && win_valid &&
                      ({1'b0, win_prio} > level_o);
    assign base_sel = alt_sel_i ? ALT_BASE : PRI_BASE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_WAIT;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: state_d = cycle_start ? ST_EVAL : ST_WAIT;
            ST_EVAL: begin
                if (win_go)
                    state_d = ST_TAKE;
                else
                    state_d = cycle_start ? ST_EVAL : ST_WAIT;
            end
            ST_TAKE: state_d = cycle_start ? ST_EVAL : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // Registered vector and level, captured on the winning edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr_o <= '0;
            new_ipl_o  <= '0;
        end else if (win_go) begin
            vec_addr_o <= base_sel + ADDR_W'({win_idx, 1'b0});
            new_ipl_o  <= win_prio;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        take_o = (state_q == ST_TAKE);
        wake_o = take_o & sleep_i;
    end

    a_r3_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ({1'b0, new_ipl_o} > $past(level_o)));

    a_r4_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (level_o[PRIO_W-1:0] == new_ipl_o));

    a_r8_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(trap_i));

    a_r9_wake_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (take_o && sleep_i));

    a_r5_vector_even_offset: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o[0] == PRI_BASE[0] || vec_addr_o[0] == ALT_BASE[0]));

endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;

    localparam int N     = 8;
    localparam int PW    = 3;
    localparam int AW    = 16;
    localparam int IW    = 3;
    localparam int PBASE = 16'h0004;
    localparam int ABASE = 16'h0084;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_start = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [N-1:0]  flag_clr_i = '0;
    logic [N-1:0]  flags_o;
    logic          en_we_i = 1'b0;
    logic [N-1:0]  en_wdata_i = '0;
    logic          prio_we_i = 1'b0;
    logic [IW-1:0] prio_sel_i = '0;
    logic [PW-1:0] prio_wdata_i = '0;
    logic          ipl_we_i = 1'b0;
    logic [PW-1:0] ipl_wdata_i = '0;
    logic          alt_sel_i = 1'b0;
    logic          trap_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic          take_o;
    logic [AW-1:0] vec_addr_o;
    logic [PW-1:0] new_ipl_o;
    logic [PW:0]   level_o;
    logic          wake_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .req_i(req_i),
        .flag_clr_i(flag_clr_i), .flags_o(flags_o), .en_we_i(en_we_i),
        .en_wdata_i(en_wdata_i), .prio_we_i(prio_we_i), .prio_sel_i(prio_sel_i),
        .prio_wdata_i(prio_wdata_i), .ipl_we_i(ipl_we_i), .ipl_wdata_i(ipl_wdata_i),
        .alt_sel_i(alt_sel_i), .trap_i(trap_i), .sleep_i(sleep_i), .take_o(take_o),
        .vec_addr_o(vec_addr_o), .new_ipl_o(new_ipl_o), .level_o(level_o),
        .wake_o(wake_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_flags = 0, m_en = 0, m_ipl = 0, m_phase = 0;
    int m_prio[N];
    bit m_take = 0;
    int m_vec = 0, m_nipl = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = 0; m_en = 0; m_ipl = 0; m_phase = 0;
            m_take = 0; m_vec = 0; m_nipl = 0;
            for (int i = 0; i < N; i++) m_prio[i] = 0;
        end else begin
            bit go;
            int best, bidx, lvl;
            go = 0; best = 0; bidx = 0;
            if (m_phase == 1) begin
                for (int i = 0; i < N; i++)
                    if (m_flags[i] && m_en[i] && m_prio[i] > best) begin
                        best = m_prio[i];
                        bidx = i;
                    end
                lvl = trap_i ? 8 : m_ipl;
                go  = (best > lvl);
            end
            m_take = go;
            if (go) begin
                m_vec  = (alt_sel_i ? ABASE : PBASE) + 2 * bidx;
                m_nipl = best;
            end
            m_phase = go ? 2 : (cycle_start ? 1 : 0);
            if (go) m_ipl = best;
            else if (ipl_we_i) m_ipl = ipl_wdata_i;
            for (int i = 0; i < N; i++) begin
                if (cycle_start && req_i[i]) m_flags[i] = 1'b1;
                else if (flag_clr_i[i]) m_flags[i] = 1'b0;
            end
            if (en_we_i) m_en = en_wdata_i;
            if (prio_we_i) m_prio[prio_sel_i] = prio_wdata_i;
        end
    end

    bit compare_on = 0;
    always @(negedge clk) begin
        if (rst_n && compare_on) begin
            check(take_o === m_take, "R3/R2/R6/R8 take", take_o, m_take);
            if (m_take) begin
                check(vec_addr_o == AW'(m_vec), "R5/R6 vector", vec_addr_o, m_vec);
                check(new_ipl_o == PW'(m_nipl), "R4 new level", new_ipl_o, m_nipl);
            end
            check(wake_o === (m_take && sleep_i), "R9 wake", wake_o, m_take && sleep_i);
            check(level_o == {trap_i, PW'(m_ipl)}, "R7/R8 level", level_o, {trap_i, PW'(m_ipl)});
            check(flags_o == N'(m_flags), "R1/R10 flags", flags_o, m_flags & 8'hFF);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        cycle_start = 0; req_i = '0; flag_clr_i = '0;
        en_we_i = 0; prio_we_i = 0; ipl_we_i = 0;
    endtask

    task automatic set_prio(input int idx, input int p);
        prio_we_i = 1; prio_sel_i = IW'(idx); prio_wdata_i = PW'(p);
        tick();
    endtask

    task automatic set_en(input logic [N-1:0] v);
        en_we_i = 1; en_wdata_i = v;
        tick();
    endtask

    task automatic set_ipl(input int v);
        ipl_we_i = 1; ipl_wdata_i = PW'(v);
        tick();
    endtask

    // One instruction cycle: sample, evaluate, possible take
    task automatic instr(input logic [N-1:0] rq);
        cycle_start = 1; req_i = rq;
        tick(); tick(); tick();
    endtask

    initial begin
        #1;
        repeat (3) @(negedge clk);
        // Reset state
        check(take_o == 0 && wake_o == 0, "R3 reset take", take_o, 0);
        check(flags_o == 0, "R1 reset flags", flags_o, 0);
        check(level_o == 0, "R8 reset level", level_o, 0);
        #1 rst_n = 1;
        compare_on = 1;
        tick();

        // R11 config; R3 main take, R5 primary table
        set_prio(2, 3); set_prio(5, 5); set_prio(6, 4); set_prio(1, 4); set_prio(7, 0);
        set_en(8'hFF);
        cycle_start = 1; req_i = 8'b0010_0100;
        tick();
        tick();
        check(take_o == 1, "R3 take source 5", take_o, 1);
        check(vec_addr_o == 16'h000E, "R5 vector source 5", vec_addr_o, 16'h000E);
        check(level_o == 5, "R4 level raised", level_o, 5);
        tick();

        // Equal priority blocked, R9 sleep wake after software lowering
        sleep_i = 1;
        instr(8'b0010_0000);
        check(take_o == 0, "R3 equal blocked", take_o, 0);
        flag_clr_i = 8'b0010_0000; tick();           // R10
        set_ipl(0);                                  // R7
        cycle_start = 1; tick(); tick();
        check(take_o == 1 && wake_o == 1, "R9 wake with take", wake_o, 1);
        check(new_ipl_o == 3, "R4 source 2 level", new_ipl_o, 3);
        tick();
        sleep_i = 0;
        flag_clr_i = 8'hFF; tick();
        set_ipl(0);

        // R6 tie between 1 and 6, alt table R5
        alt_sel_i = 1;
        cycle_start = 1; req_i = 8'b0100_0010; tick(); tick();
        check(vec_addr_o == 16'h0086, "R6 lowest index tie", vec_addr_o, 16'h0086);
        tick();
        alt_sel_i = 0;
        flag_clr_i = 8'hFF; tick(); set_ipl(0);

        // R2 priority zero source never fires
        instr(8'b1000_0000);
        check(level_o == 0, "R2 zero priority ignored", level_o, 0);
        flag_clr_i = 8'hFF; tick();

        // R8 trap blocks
        trap_i = 1;
        cycle_start = 1; req_i = 8'b0010_0000; tick(); tick();
        check(take_o == 0 && level_o == 8, "R8 trap blocks", level_o, 8);
        tick();
        trap_i = 0;
        flag_clr_i = 8'hFF; tick();

        // R1 set wins over clear in same cycle
        cycle_start = 1; req_i = 8'b0000_0100; flag_clr_i = 8'b0000_0100; tick();
        check(flags_o[2] == 1, "R1 set beats clear", flags_o[2], 1);
        // R7 take load beats software write in the EVAL cycle
        ipl_we_i = 1; ipl_wdata_i = 3'd1; tick();
        check(level_o == 3, "R7 take over write", level_o, 3);
        tick();
        flag_clr_i = 8'hFF; tick(); set_ipl(0);

        // Pseudo-random stream against the model
        for (int k = 0; k < 2000; k++) begin
            cycle_start = ($urandom_range(0, 2) == 0);
            req_i       = N'($urandom) & N'($urandom);
            flag_clr_i  = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            ipl_we_i    = ($urandom_range(0, 7) == 0);
            ipl_wdata_i = PW'($urandom_range(0, 4));
            prio_we_i   = ($urandom_range(0, 9) == 0);
            prio_sel_i  = IW'($urandom);
            prio_wdata_i = PW'($urandom);
            en_we_i     = ($urandom_range(0, 15) == 0);
            en_wdata_i  = N'($urandom);
            alt_sel_i   = $urandom_range(0, 1);
            trap_i      = ($urandom_range(0, 9) == 0);
            sleep_i     = $urandom_range(0, 1);
            @(negedge clk); #1;
        end
        tick(); tick();
        compare_on = 0;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule